// File: doc/BRIEF.md
# Serial character parity insert and check

This block sits beside the shift registers of a serial character port and handles the parity bit in both directions. On the transmit side it is purely combinational. It takes the word the host wrote and, when parity is on, replaces the top bit of the character with a computed parity bit. It does not add an extra bit. The character is 7 bits wide or 8 bits wide, chosen by a length control, so the position of the replaced bit moves with that control.

On the receive side the shifter hands over the assembled character with a one-cycle strobe. The block counts the ones over the character bits, parity bit included, and compares that count with the selected sense. A mismatch sets a sticky error flag. The flag drives an interrupt request when the parity interrupt enable is high. The flag is cleared by a one-cycle clear pulse.

Top module: `uart_par_top`

## Requirements
- R1: With parity enabled, 8-bit length (`len_full_i`=1) and even sense (`par_odd_i`=0), `tx_word_o` equals `tx_word_i` with bit 7 replaced so that bits 7..0 of the output hold an even number of ones. For 0x35 the output is 0x35.
- R2: Odd sense (`par_odd_i`=1) makes the covered bits of `tx_word_o` hold an odd number of ones. For 0x35 at 8-bit length the output is 0xB5.
- R3: At 7-bit length (`len_full_i`=0), parity replaces bit 6 and covers bits 6..0. Bit 7 of `tx_word_o` equals bit 7 of `tx_word_i`.
- R4: With `par_en_i`=0, `tx_word_o` equals `tx_word_i` exactly.
- R5: When `rx_valid_i` is high and parity is enabled, `par_err_o` becomes 1 after that clock edge if the ones count over bits 7..0 (8-bit length) or bits 6..0 (7-bit length) of `rx_word_i` is odd in even sense or even in odd sense. Bit 7 is ignored at 7-bit length.
- R6: The flag does not set when `rx_valid_i` is low, or when `par_en_i` is 0, whatever the received word.
- R7: Once set, `par_err_o` stays 1 until a cycle with `err_clr_i` high, after which it reads 0.
- R8: A parity error detected in the same cycle as `err_clr_i` leaves `par_err_o` at 1.
- R9: `irq_o` is 1 exactly when `par_err_o` is 1 and `par_ie_i` is 1.
- R10: After `rst_ni` is asserted low, `par_err_o` and `irq_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_en_i | input | 1 | Parity enable |
| par_odd_i | input | 1 | 0 even sense, 1 odd sense |
| len_full_i | input | 1 | 0 for 7-bit characters, 1 for 8-bit characters |
| par_ie_i | input | 1 | Parity interrupt enable |
| tx_word_i | input | DATA_W | Word written for transmission |
| tx_word_o | output | DATA_W | Word handed to the transmit shifter |
| rx_word_i | input | DATA_W | Assembled received character |
| rx_valid_i | input | 1 | One-cycle strobe: received character complete |
| err_clr_i | input | 1 | One-cycle clear of the error flag |
| par_err_o | output | 1 | Sticky parity error flag |
| irq_o | output | 1 | Parity interrupt request |

## Verification
The error-flag set path and the clear path can act in the same cycle. The bench provokes this by asserting `err_clr_i` together with a `rx_valid_i` strobe that carries a bad character. It then expects the flag to read 1 on the following cycle. A matching case pairs the clear with a good character and expects 0, so the bench can tell the priority order apart from a flag that merely stays stuck.

// File: rtl/uart_par_pkg.sv
package uart_par_pkg;
  typedef enum logic {LEN_SHORT = 1'b0, LEN_FULL = 1'b1} len_e;
  typedef enum logic {SENSE_EVEN = 1'b0, SENSE_ODD = 1'b1} sense_e;
endpackage

// File: rtl/uart_par_tree.sv
module uart_par_tree #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              par_o
);
  logic [DATA_W-1:0] sel;
  assign sel   = word_i & mask_i;
  assign par_o = ^sel;
endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
  import uart_par_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              par_en_i,
  input  sense_e            sense_i,
  input  len_e              len_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned TOP = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [DATA_W-1:0] data_mask;
  logic              data_par;

  // Data bits below the slot that parity overwrites
  assign data_mask = (len_i == LEN_FULL) ? (ONES >> 1) : (ONES >> 2);

  uart_par_tree #(.DATA_W(DATA_W)) u_tree (
    .word_i (word_i),
    .mask_i (data_mask),
    .par_o  (data_par)
  );

  always_comb begin
    word_o = word_i;
    if (par_en_i) begin
      if (len_i == LEN_FULL) word_o[TOP]   = data_par ^ (sense_i == SENSE_ODD);
      else                   word_o[TOP-1] = data_par ^ (sense_i == SENSE_ODD);
    end
  end
endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx
  import uart_par_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_en_i,
  input  sense_e            sense_i,
  input  len_e              len_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              valid_i,
  input  logic              clr_i,
  output logic              err_o
);
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [DATA_W-1:0] chr_mask;
  logic              chr_par;
  logic              bad;
  logic              err_q;

  assign chr_mask = (len_i == LEN_FULL) ? ONES : (ONES >> 1);

  uart_par_tree #(.DATA_W(DATA_W)) u_tree (
    .word_i (word_i),
    .mask_i (chr_mask),
    .par_o  (chr_par)
  );

  // Even sense wants xor 0, odd sense wants xor 1
  assign bad = valid_i & par_en_i & (chr_par ^ (sense_i == SENSE_ODD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (bad)   err_q <= 1'b1;  // set wins over clear
    else if (clr_i) err_q <= 1'b0;
  end

  assign err_o = err_q;
endmodule

// File: rtl/uart_par_top.sv
module uart_par_top
  import uart_par_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              len_full_i,
  input  logic              par_ie_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic [DATA_W-1:0] tx_word_o,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rx_valid_i,
  input  logic              err_clr_i,
  output logic              par_err_o,
  output logic              irq_o
);
  sense_e sense;
  len_e   len;

  assign sense = sense_e'(par_odd_i);
  assign len   = len_e'(len_full_i);

  uart_par_tx #(.DATA_W(DATA_W)) u_tx (
    .par_en_i (par_en_i),
    .sense_i  (sense),
    .len_i    (len),
    .word_i   (tx_word_i),
    .word_o   (tx_word_o)
  );

  uart_par_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .par_en_i (par_en_i),
    .sense_i  (sense),
    .len_i    (len),
    .word_i   (rx_word_i),
    .valid_i  (rx_valid_i),
    .clr_i    (err_clr_i),
    .err_o    (par_err_o)
  );

  assign irq_o = par_err_o & par_ie_i;
endmodule

// File: rtl/uart_par_chk.sv
module uart_par_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              par_en_i,
  input logic              par_odd_i,
  input logic              len_full_i,
  input logic              par_ie_i,
  input logic [DATA_W-1:0] tx_word_i,
  input logic [DATA_W-1:0] tx_word_o,
  input logic              rx_valid_i,
  input logic              err_clr_i,
  input logic              par_err_o,
  input logic              irq_o
);
  assert_tx_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_en_i && len_full_i |-> ((^tx_word_o) == par_odd_i));

  assert_tx_short_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_en_i && !len_full_i |->
      ((^tx_word_o[DATA_W-2:0]) == par_odd_i) && (tx_word_o[DATA_W-1] == tx_word_i[DATA_W-1]));

  assert_tx_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_en_i |-> tx_word_o == tx_word_i);

  assert_rise_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(par_err_o) |-> $past(rx_valid_i && par_en_i));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o && !err_clr_i |=> par_err_o);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !(rx_valid_i && par_en_i) |=> !par_err_o);

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> par_err_o && par_ie_i);

  assert_irq_raise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o && par_ie_i |-> irq_o);
endmodule

bind uart_par_top uart_par_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .par_en_i   (par_en_i),
  .par_odd_i  (par_odd_i),
  .len_full_i (len_full_i),
  .par_ie_i   (par_ie_i),
  .tx_word_i  (tx_word_i),
  .tx_word_o  (tx_word_o),
  .rx_valid_i (rx_valid_i),
  .err_clr_i  (err_clr_i),
  .par_err_o  (par_err_o),
  .irq_o      (irq_o)
);

// File: tb/uart_par_top_tb.sv
module uart_par_top_tb;
  localparam int unsigned DATA_W = 8;

  typedef struct {
    int          kind;  // 0 tx word, 1 flag, 2 irq
    logic [7:0]  exp;
    string       req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              par_en = 1'b0, par_odd = 1'b0, len_full = 1'b1, par_ie = 1'b0;
  logic [DATA_W-1:0] tx_in = '0, tx_out, rx_word = '0;
  logic              rx_valid = 1'b0, err_clr = 1'b0;
  logic              par_err, irq;

  item_t sb[$];
  int    checks = 0, errors = 0;
  logic  exp_flag = 1'b0;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  uart_par_top #(.DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .par_en_i(par_en), .par_odd_i(par_odd),
    .len_full_i(len_full), .par_ie_i(par_ie), .tx_word_i(tx_in), .tx_word_o(tx_out),
    .rx_word_i(rx_word), .rx_valid_i(rx_valid), .err_clr_i(err_clr),
    .par_err_o(par_err), .irq_o(irq)
  );

  function automatic logic [7:0] ref_tx(logic [7:0] w, logic en, logic odd, logic full);
    int n;
    int ones = 0;
    logic [7:0] r = w;
    if (!en) return w;
    n = full ? 7 : 6;
    for (int i = 0; i < n; i++) ones += int'(w[i]);
    r[n] = (ones % 2 == 1) ^ odd;
    return r;
  endfunction

  function automatic logic ref_bad(logic [7:0] w, logic odd, logic full);
    int n;
    int ones = 0;
    n = full ? 8 : 7;
    for (int i = 0; i < n; i++) ones += int'(w[i]);
    return odd ? (ones % 2 == 0) : (ones % 2 == 1);
  endfunction

  // Monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = (it.kind == 0) ? tx_out : (it.kind == 1) ? {7'd0, par_err} : {7'd0, irq};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic tx_case(logic [7:0] w, logic en, logic odd, logic full, string req);
    @(posedge clk); #1;
    tx_in = w; par_en = en; par_odd = odd; len_full = full;
    push(0, ref_tx(w, en, odd, full), req);
  endtask

  task automatic rx_case(logic [7:0] w, logic en, logic odd, logic full, logic vld,
                         logic clr, logic ie, string req);
    logic set;
    @(posedge clk); #1;
    rx_word = w; par_en = en; par_odd = odd; len_full = full;
    rx_valid = vld; err_clr = clr; par_ie = ie;
    set = vld && en && ref_bad(w, odd, full);
    exp_flag = set ? 1'b1 : (clr ? 1'b0 : exp_flag);
    @(posedge clk); #1;
    rx_valid = 1'b0; err_clr = 1'b0;
    push(1, {7'd0, exp_flag}, req);
    push(2, {7'd0, exp_flag & ie}, "R9");
  endtask

  initial begin
    #1;
    push(1, 8'd0, "R10");
    push(2, 8'd0, "R10");
    @(posedge clk); #1;
    rst_n = 1'b1;

    // Transmit side
    tx_case(8'h35, 1, 0, 1, "R1");
    tx_case(8'hB5, 1, 0, 1, "R1");
    tx_case(8'h35, 1, 1, 1, "R2");
    tx_case(8'h01, 1, 1, 1, "R2");
    tx_case(8'h35, 1, 0, 0, "R3");
    tx_case(8'hB5, 1, 1, 0, "R3");
    tx_case(8'hC3, 1, 1, 0, "R3");
    tx_case(8'h35, 0, 1, 1, "R4");
    tx_case(8'hFF, 0, 0, 0, "R4");

    // Receive: good characters keep flag low
    rx_case(8'h35, 1, 0, 1, 1, 0, 1, "R5");
    rx_case(8'h75, 1, 1, 0, 1, 0, 1, "R5");
    rx_case(8'hB5, 1, 0, 0, 1, 0, 1, "R5");  // bit 7 ignored at 7-bit length
    // Ignored cases: bad words without strobe or with parity off
    rx_case(8'h01, 1, 0, 1, 0, 0, 1, "R6");
    rx_case(8'h01, 0, 0, 1, 1, 0, 1, "R6");
    // Bad word sets flag, irq masked
    rx_case(8'h01, 1, 0, 1, 1, 0, 0, "R5");
    rx_case(8'h35, 1, 0, 1, 1, 0, 0, "R7");
    rx_case(8'h35, 1, 0, 1, 0, 0, 1, "R9");
    rx_case(8'h35, 1, 0, 1, 0, 1, 1, "R7");
    // Odd sense, 7-bit, bad
    rx_case(8'h35, 1, 1, 0, 1, 0, 1, "R5");
    // Collision: clear with bad character keeps flag set
    rx_case(8'h00, 1, 1, 1, 1, 1, 1, "R8");
    // Clear with good character clears
    rx_case(8'h01, 1, 1, 1, 1, 1, 1, "R8");

    // Reset mid-run
    rx_case(8'h01, 1, 0, 1, 1, 0, 1, "R5");
    @(posedge clk); #1;
    rst_n = 1'b0;
    exp_flag = 1'b0;
    #1;
    push(1, 8'd0, "R10");
    push(2, 8'd0, "R10");
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule